// File: doc/BRIEF.md
# Dual Down-Counter Timer Register Block

A byte-wide peripheral with sixteen registers, selected by a 4-bit address through chip select, read and write strobes. It holds two 16-bit down-counting timers, each with a reload latch and a control register. It also holds two parallel ports with direction registers, a serial data byte and an interrupt unit that combines pending flags with a mask into a single interrupt output. The time-of-day addresses are part of the map, but writes to them are ignored and reads return zero.

A timer with its start bit set counts down once per clock. When it steps past zero it reloads from its latch and raises its flag. In one-shot mode it also clears its own start bit at that point. Reading the interrupt status address returns the pending flags with a summary bit and clears them. The mask is updated with set/clear semantics.

Read data is registered. It appears on `rdData` after the clock edge that samples the read strobe and holds until the next read.

Top module: `dual_timer_regs`

## Requirements
- R1: Address map: 0/1 port A/B data, 2/3 port A/B direction, 4/5 timer A low/high byte, 6/7 timer B low/high byte, 8–B time-of-day, C serial data, D interrupt status/mask, E/F control A/B. A port read returns, for each bit, the output register where the direction bit is 1 and the input pin where it is 0. The port pins carry the output register and the direction register.
- R2: A write to a timer's low-byte address replaces only bits 7:0 of that timer's latch. The counter is not changed.
- R3: A write to a timer's high-byte address replaces bits 15:8 of the latch. If the timer's start bit (control bit 0) is 0, the counter takes the whole new latch value at that edge. If the start bit is 1, the counter is not reloaded.
- R4: Reads of the timer byte addresses return the matching byte of the live counter, not the latch.
- R5: While started, a timer decrements once per clock. On the clock where it is at zero, it reloads from its latch and sets flag bit 0 (timer A) or flag bit 1 (timer B), so one period spans latch+1 clocks.
- R6: With control bit 3 set, a timer clears its start bit on the clock where it reloads after reaching zero.
- R7: Writing control bit 4 as 1 loads the counter from the latch. Bit 4 always reads back as 0.
- R8: A read of address D returns flags in bits 4:0, with bit 7 = 1 when any flag is set. The same read clears all flags. An event arriving in the same cycle as the read is kept.
- R9: A write to address D with bit 7 = 1 sets the mask bits selected by bits 4:0. With bit 7 = 0, it clears those mask bits.
- R10: A write to address C stores the byte, which reads back at C, and sets flag bit 3.
- R11: `irq` is high whenever any flag is set together with its mask bit. After a read of address D it is low from the following cycle.
- R12: Writes to addresses 8–B change no state, and reads of those addresses return 0.
- R13: Reset clears the ports, direction registers, latches, counters, controls, serial byte, mask and flags, so `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| portAIn | input | 8 | Port A input pins |
| portBIn | input | 8 | Port B input pins |
| portAOut | output | 8 | Port A output register |
| portAOe | output | 8 | Port A direction (1 = drive) |
| portBOut | output | 8 | Port B output register |
| portBOe | output | 8 | Port B direction (1 = drive) |
| irq | output | 1 | Interrupt request, active high |

## Verification
Each register write takes effect at the clock edge that samples it. Read data appears after that same edge. `irq` follows the flags and mask combinationally, so it changes right after the edge that updates them. A timer that is started at edge S with latch value N first reaches its reload edge at S+N+1. The bench drives each access for exactly one edge and counts edges from the start write. It samples `rdData` and `irq` two nanoseconds after an edge, well before the next one. Timer tests stop the counter before reading it, so counter values are predicted exactly from the number of edges that elapsed.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;
  localparam int FLAG_W = 5;

  localparam logic [ADDR_W-1:0] A_PORTA = 4'h0;
  localparam logic [ADDR_W-1:0] A_PORTB = 4'h1;
  localparam logic [ADDR_W-1:0] A_DIRA  = 4'h2;
  localparam logic [ADDR_W-1:0] A_DIRB  = 4'h3;
  localparam logic [ADDR_W-1:0] A_TALO  = 4'h4;
  localparam logic [ADDR_W-1:0] A_TAHI  = 4'h5;
  localparam logic [ADDR_W-1:0] A_TBLO  = 4'h6;
  localparam logic [ADDR_W-1:0] A_TBHI  = 4'h7;
  localparam logic [ADDR_W-1:0] A_SER   = 4'hC;
  localparam logic [ADDR_W-1:0] A_ICR   = 4'hD;
  localparam logic [ADDR_W-1:0] A_CTLA  = 4'hE;
  localparam logic [ADDR_W-1:0] A_CTLB  = 4'hF;

  localparam int CTL_START   = 0;
  localparam int CTL_ONESHOT = 3;
  localparam int CTL_LOAD    = 4;

  localparam int FLG_TA  = 0;
  localparam int FLG_TB  = 1;
  localparam int FLG_SER = 3;
  localparam int ICR_SET = 7;

  typedef struct packed {
    logic wrPortA;
    logic wrPortB;
    logic wrDirA;
    logic wrDirB;
    logic wrLoA;
    logic wrHiA;
    logic wrLoB;
    logic wrHiB;
    logic wrSer;
    logic wrIcr;
    logic wrCtlA;
    logic wrCtlB;
    logic rdAny;
    logic rdIcr;
  } regStrobes_t;
endpackage

// File: rtl/dtr_ctrl.sv
module dtr_ctrl
  import dtr_pkg::*;
(
  input  logic              cs,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobes_t       strb
);
  logic wrHit;
  logic rdHit;

  assign wrHit = cs & wrEn;
  assign rdHit = cs & rdEn;

  always_comb begin
    strb = '0;
    strb.rdAny = rdHit;
    strb.rdIcr = rdHit && (addr == A_ICR);
    if (wrHit) begin
      unique case (addr)
        A_PORTA: strb.wrPortA = 1'b1;
        A_PORTB: strb.wrPortB = 1'b1;
        A_DIRA:  strb.wrDirA  = 1'b1;
        A_DIRB:  strb.wrDirB  = 1'b1;
        A_TALO:  strb.wrLoA   = 1'b1;
        A_TAHI:  strb.wrHiA   = 1'b1;
        A_TBLO:  strb.wrLoB   = 1'b1;
        A_TBHI:  strb.wrHiB   = 1'b1;
        A_SER:   strb.wrSer   = 1'b1;
        A_ICR:   strb.wrIcr   = 1'b1;
        A_CTLA:  strb.wrCtlA  = 1'b1;
        A_CTLB:  strb.wrCtlB  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dtr_timer.sv
module dtr_timer
  import dtr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DAT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrLo,
  input  logic             wrHi,
  input  logic             wrCtl,
  input  logic [DAT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [DAT_W-1:0] ctlOut,
  output logic             underflow
);
  localparam int HI_W = CNT_W - DAT_W;

  logic [CNT_W-1:0] latch;
  logic [DAT_W-1:0] ctl;
  logic             running;
  logic             atZero;
  logic             forceLoad;

  assign running   = ctl[CTL_START];
  assign atZero    = (count == '0);
  assign underflow = running & atZero;
  assign forceLoad = wrCtl & wrData[CTL_LOAD];
  assign ctlOut    = ctl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latch <= '0;
      count <= '0;
      ctl   <= '0;
    end else begin
      if (wrLo) latch[DAT_W-1:0] <= wrData;
      if (wrHi) latch[CNT_W-1:DAT_W] <= wrData[HI_W-1:0];

      if (forceLoad)
        count <= latch;
      else if (wrHi && !running)
        count <= {wrData[HI_W-1:0], latch[DAT_W-1:0]};
      else if (running)
        count <= atZero ? latch : count - 1'b1;

      if (wrCtl)
        ctl <= wrData & ~(DAT_W'(1) << CTL_LOAD);
      else if (underflow && ctl[CTL_ONESHOT])
        ctl[CTL_START] <= 1'b0;
    end
  end

  p_reload_at_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    running && atZero |=> count == $past(latch));
  p_decrement_r5: assert property (@(posedge clk) disable iff (!rstN)
    running && !atZero && !forceLoad |=> count == $past(count) - 1'b1);
  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    underflow && ctl[CTL_ONESHOT] && !wrCtl |=> !ctl[CTL_START]);
  p_load_bit_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrCtl |=> !ctl[CTL_LOAD]);
  p_lo_keeps_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrLo && !running && !wrCtl |=> $stable(count));
endmodule

// File: rtl/dtr_datapath.sv
module dtr_datapath
  import dtr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] portAIn,
  input  logic [BYTE_W-1:0] portBIn,
  input  logic [CNT_W-1:0]  countA,
  input  logic [CNT_W-1:0]  countB,
  input  logic [BYTE_W-1:0] ctlA,
  input  logic [BYTE_W-1:0] ctlB,
  input  logic              uflA,
  input  logic              uflB,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] portAOut,
  output logic [BYTE_W-1:0] portAOe,
  output logic [BYTE_W-1:0] portBOut,
  output logic [BYTE_W-1:0] portBOe,
  output logic              irq
);
  localparam int PAD_W = BYTE_W - FLAG_W - 1;

  logic [BYTE_W-1:0] serByte;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] mask;
  logic [FLAG_W-1:0] flagSet;
  logic [BYTE_W-1:0] rdMux;
  logic              newEvent;

  always_comb begin
    flagSet = '0;
    flagSet[FLG_TA]  = uflA;
    flagSet[FLG_TB]  = uflB;
    flagSet[FLG_SER] = strb.wrSer;
  end
  assign newEvent = |flagSet;
  assign irq      = |(flags & mask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portAOut <= '0;
      portBOut <= '0;
      portAOe  <= '0;
      portBOe  <= '0;
      serByte  <= '0;
      flags    <= '0;
      mask     <= '0;
    end else begin
      if (strb.wrPortA) portAOut <= wrData;
      if (strb.wrPortB) portBOut <= wrData;
      if (strb.wrDirA)  portAOe  <= wrData;
      if (strb.wrDirB)  portBOe  <= wrData;
      if (strb.wrSer)   serByte  <= wrData;
      flags <= (strb.rdIcr ? '0 : flags) | flagSet;
      if (strb.wrIcr) begin
        if (wrData[ICR_SET]) mask <= mask | wrData[FLAG_W-1:0];
        else                 mask <= mask & ~wrData[FLAG_W-1:0];
      end
    end
  end

  always_comb begin
    rdMux = '0;
    unique case (addr)
      A_PORTA: rdMux = (portAOut & portAOe) | (portAIn & ~portAOe);
      A_PORTB: rdMux = (portBOut & portBOe) | (portBIn & ~portBOe);
      A_DIRA:  rdMux = portAOe;
      A_DIRB:  rdMux = portBOe;
      A_TALO:  rdMux = countA[BYTE_W-1:0];
      A_TAHI:  rdMux = countA[CNT_W-1:BYTE_W];
      A_TBLO:  rdMux = countB[BYTE_W-1:0];
      A_TBHI:  rdMux = countB[CNT_W-1:BYTE_W];
      A_SER:   rdMux = serByte;
      A_ICR:   rdMux = {|flags, {PAD_W{1'b0}}, flags};
      A_CTLA:  rdMux = ctlA;
      A_CTLB:  rdMux = ctlB;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (strb.rdAny) rdData <= rdMux;
  end

  p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdIcr && !newEvent |=> flags == '0);
  p_irq_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdIcr && !newEvent |=> !irq);
  p_mask_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrIcr && wrData[ICR_SET] |=>
      (mask & $past(wrData[FLAG_W-1:0])) == $past(wrData[FLAG_W-1:0]));
  p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrIcr && !wrData[ICR_SET] |=> (mask & $past(wrData[FLAG_W-1:0])) == '0);
  p_serial_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSer |=> flags[FLG_SER] && serByte == $past(wrData));
endmodule

// File: rtl/dual_timer_regs.sv
module dual_timer_regs
  import dtr_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic [BYTE_W-1:0] portAIn,
  input  logic [BYTE_W-1:0] portBIn,
  output logic [BYTE_W-1:0] portAOut,
  output logic [BYTE_W-1:0] portAOe,
  output logic [BYTE_W-1:0] portBOut,
  output logic [BYTE_W-1:0] portBOe,
  output logic              irq
);
  localparam int N_TMR = 2;

  regStrobes_t       strb;
  logic [N_TMR-1:0]  loWr;
  logic [N_TMR-1:0]  hiWr;
  logic [N_TMR-1:0]  ctlWr;
  logic [N_TMR-1:0]  ufl;
  logic [TIMER_W-1:0] tCount [N_TMR];
  logic [BYTE_W-1:0]  tCtl   [N_TMR];

  assign loWr  = {strb.wrLoB, strb.wrLoA};
  assign hiWr  = {strb.wrHiB, strb.wrHiA};
  assign ctlWr = {strb.wrCtlB, strb.wrCtlA};

  dtr_ctrl uCtrl (
    .cs   (cs),
    .rdEn (rdEn),
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : gTimer
    dtr_timer #(.CNT_W(TIMER_W), .DAT_W(BYTE_W)) uTimer (
      .clk       (clk),
      .rstN      (rstN),
      .wrLo      (loWr[i]),
      .wrHi      (hiWr[i]),
      .wrCtl     (ctlWr[i]),
      .wrData    (wrData),
      .count     (tCount[i]),
      .ctlOut    (tCtl[i]),
      .underflow (ufl[i])
    );
  end

  dtr_datapath #(.CNT_W(TIMER_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addr     (addr),
    .wrData   (wrData),
    .portAIn  (portAIn),
    .portBIn  (portBIn),
    .countA   (tCount[0]),
    .countB   (tCount[1]),
    .ctlA     (tCtl[0]),
    .ctlB     (tCtl[1]),
    .uflA     (ufl[0]),
    .uflB     (ufl[1]),
    .rdData   (rdData),
    .portAOut (portAOut),
    .portAOe  (portAOe),
    .portBOut (portBOut),
    .portBOe  (portBOe),
    .irq      (irq)
  );

  p_irq_reset_r13: assert property (@(posedge clk) $rose(rstN) |-> !irq);
endmodule

// File: tb/tb_dual_timer_regs.sv
module tb_dual_timer_regs;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cs = 1'b0, rdEn = 1'b0, wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] portAIn = '0, portBIn = '0;
  logic [7:0] portAOut, portAOe, portBOut, portBOe;
  logic       irq;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_timer_regs dut (
    .clk(clk), .rstN(rstN), .cs(cs), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .portAIn(portAIn), .portBIn(portBIn),
    .portAOut(portAOut), .portAOe(portAOe), .portBOut(portBOut),
    .portBOe(portBOe), .irq(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    #1 cs = 1'b0; wrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; rdEn = 1'b1; addr = a;
    @(posedge clk);
    #1 cs = 1'b0; rdEn = 1'b0;
    #1 v = rdData;
  endtask

  task automatic tReset();
    logic [7:0] v;
    check("R13 irq", irq, 0);
    check("R13 portAOe", portAOe, 0);
    rd(4'h2, v); check("R13 dirA", v, 8'h00);
    rd(4'hD, v); check("R13 flags", v, 8'h00);
    rd(4'hE, v); check("R13 ctlA", v, 8'h00);
    rd(4'h5, v); check("R13 countA hi", v, 8'h00);
  endtask

  task automatic tLatchBytes();
    logic [7:0] v;
    wr(4'h4, 8'h34); wr(4'h5, 8'h12);
    rd(4'h4, v); check("R3 R4 count lo after stopped hi write", v, 8'h34);
    rd(4'h5, v); check("R3 R4 count hi", v, 8'h12);
    wr(4'h4, 8'h99);
    rd(4'h4, v); check("R2 lo write leaves counter", v, 8'h34);
  endtask

  task automatic tPeriodic();
    logic [7:0] v;
    wr(4'hD, 8'h81);
    wr(4'h4, 8'h03); wr(4'h5, 8'h00);
    wr(4'hE, 8'h01);
    repeat (3) @(posedge clk);
    #1 check("R5 no flag before latch+1 clocks", irq, 0);
    @(posedge clk);
    #1 check("R5 R11 irq at reload", irq, 1);
    wr(4'hE, 8'h00);
    check("R11 irq held before status read", irq, 1);
    rd(4'hD, v); check("R8 status summary", v, 8'h81);
    check("R11 irq drops after status read", irq, 0);
    rd(4'hD, v); check("R8 flags cleared", v, 8'h00);
  endtask

  task automatic tRunningHiWrite();
    logic [7:0] v;
    wr(4'h6, 8'hFF); wr(4'h7, 8'h00);
    wr(4'hF, 8'h01);
    wr(4'h7, 8'h77);
    wr(4'hF, 8'h00);
    rd(4'h6, v); check("R3 running hi write no reload lo", v, 8'hFD);
    rd(4'h7, v); check("R3 running hi write no reload hi", v, 8'h00);
  endtask

  task automatic tOneShot();
    logic [7:0] v;
    wr(4'h6, 8'h02); wr(4'h7, 8'h00);
    wr(4'hF, 8'h09);
    repeat (4) @(posedge clk);
    #1;
    rd(4'hF, v); check("R6 one-shot start cleared", v, 8'h08);
    rd(4'h6, v); check("R6 R5 reloaded and halted", v, 8'h02);
    check("R11 unmasked flag no irq", irq, 0);
    rd(4'hD, v); check("R5 timer B flag", v, 8'h82);
  endtask

  task automatic tForceLoad();
    logic [7:0] v;
    wr(4'h4, 8'h66);
    wr(4'hE, 8'h10);
    rd(4'hE, v); check("R7 load bit reads 0", v, 8'h00);
    rd(4'h4, v); check("R7 forced load lo", v, 8'h66);
    rd(4'h5, v); check("R7 forced load hi", v, 8'h00);
  endtask

  task automatic tSerialMask();
    logic [7:0] v;
    wr(4'hD, 8'h88);
    check("R9 mask set alone no irq", irq, 0);
    wr(4'hC, 8'hA5);
    check("R10 R11 serial flag raises irq", irq, 1);
    wr(4'hD, 8'h08);
    check("R9 mask clear drops irq", irq, 0);
    rd(4'hC, v); check("R10 serial byte", v, 8'hA5);
    rd(4'hD, v); check("R10 R8 serial flag", v, 8'h88);
  endtask

  task automatic tPorts();
    logic [7:0] v;
    portAIn = 8'h3C; portBIn = 8'hFF;
    wr(4'h2, 8'hF0); wr(4'h0, 8'hA5);
    rd(4'h0, v); check("R1 port A mixed read", v, 8'hAC);
    check("R1 portAOut", portAOut, 8'hA5);
    check("R1 portAOe", portAOe, 8'hF0);
    wr(4'h3, 8'h0F); wr(4'h1, 8'h00);
    rd(4'h1, v); check("R1 port B mixed read", v, 8'hF0);
    check("R1 portBOe", portBOe, 8'h0F);
  endtask

  task automatic tTod();
    logic [7:0] v;
    for (int a = 8; a < 12; a++) wr(4'(a), 8'hFF);
    rd(4'h8, v); check("R12 tod read 8", v, 8'h00);
    rd(4'hB, v); check("R12 tod read B", v, 8'h00);
    rd(4'hC, v); check("R12 serial untouched", v, 8'hA5);
    rd(4'h2, v); check("R12 dirA untouched", v, 8'hF0);
    rd(4'h4, v); check("R12 countA untouched", v, 8'h66);
    rd(4'hD, v); check("R12 no flags", v, 8'h00);
    check("R12 irq low", irq, 0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tLatchBytes();
    tPeriodic();
    tRunningHiWrite();
    tOneShot();
    tForceLoad();
    tSerialMask();
    tPorts();
    tTod();
    done = 1'b1;
    finishRun();
  end
endmodule